// File: doc/BRIEF.md
# Dual-buffer Ethernet transmit controller

This block is the transmit side of a small memory-mapped Ethernet MAC. Software sees two ping-pong packet buffers, each 512 words deep. The top words of each buffer hold a length register and a control register. One global interrupt-enable register sits only in the first buffer. Software writes a frame into a buffer, sets the frame length, and then writes a command to that buffer's control register.

A plain start command streams the frame out, one byte per handshake, on an 8-bit valid/ready/last interface. A start command with the program bit also set does not transmit. Instead it loads the first six bytes of the buffer into the station MAC address register. When either operation completes, the block can raise a one-cycle interrupt pulse. A single engine serves both buffers, one operation at a time. Buffer 0 is taken first when both are waiting.

Register accesses are whole 32-bit words addressed by word index. Writes take effect at the clock edge. Reads return their data one cycle after the read strobe.

Top module: `eth_tx_frontend`

## Requirements
- R1: Word index b*512+k addresses buffer b (b = 0 or 1). For k = 509 it is the length register, which keeps the low 16 bits. For k = 511 it is the control register. For k = 510 in buffer 0 it is the global interrupt enable. Every other index is frame storage that reads back what was written. A read returns its data on reg_rdata one cycle after the strobe.
- R2: In the control word, bit 0 is Start (S), bit 1 is Program (P) and bit 3 is interrupt enable (I). A control write with S=1 and P=0 sends the buffer's frame, whose byte count is the length register, starting at the buffer's word 0.
- R3: Frame byte k is bits [8*(k%4)+7 : 8*(k%4)] of buffer word k/4, so each word goes out least significant byte first. tx_tlast is high only with the final byte.
- R4: A byte is transferred when tx_tvalid and tx_tready are both high. While tx_tvalid is high and tx_tready is low, tx_tvalid, tx_tdata and tx_tlast hold.
- R5: A control write with S=1 and P=1 streams no bytes. It sets mac_addr[47:40] to buffer byte 0, mac_addr[39:32] to byte 1, and so on down to mac_addr[7:0] = byte 5.
- R6: The control register reads back S=1 while its buffer's operation is pending or running, and P=1 as well for an address load. Both read 0 after completion. I reads back as last accepted and bit 2 reads 0.
- R7: On completion, irq is high for exactly one cycle if the I bit of the completed buffer is 1 and bit 31 of the global enable register is 1. Otherwise irq stays low.
- R8: The global enable register stores only bit 31, and the other bits read 0. Word index 1022 is plain storage and has no effect on interrupts.
- R9: A control write to a buffer whose S bit reads 1 is ignored. It starts nothing and leaves I unchanged.
- R10: A length of 0 completes at once with no bytes. A length above 2036 is treated as 2036.
- R11: A control write with S=0 starts nothing and only updates I.
- R12: After reset, irq, tx_tvalid and mac_addr are 0, and both control registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Word write strobe |
| reg_rd | input | 1 | Word read strobe |
| reg_addr | input | 10 | Word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one cycle after reg_rd |
| tx_tvalid | output | 1 | Frame byte valid |
| tx_tready | input | 1 | Sink ready for a byte |
| tx_tdata | output | 8 | Frame byte |
| tx_tlast | output | 1 | Final byte of the frame |
| mac_addr | output | 48 | Station MAC address, byte 0 in the top bits |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
The assertions check several properties on every cycle. The stream must hold its byte while stalled. P must never be set without S. Completion must clear the busy state of the buffer that finished. A control write to a busy buffer must leave its state alone. Completions must never fall on back-to-back cycles, so interrupt pulses never merge. The bench scenarios are needed for the behaviours that depend on data values: byte order across word boundaries, the six-byte address assembly, interrupt gating by both enables, clamping of the length, and the zero-length case.

// File: rtl/ethtx_pkg.sv
package ethtx_pkg;
  localparam int CTL_S   = 0;
  localparam int CTL_P   = 1;
  localparam int CTL_I   = 3;
  localparam int GIE_BIT = 31;

  typedef enum logic [2:0] {
    ENG_IDLE,
    ENG_SEND,
    ENG_MAC_HI,
    ENG_MAC_LO,
    ENG_FIN
  } eng_state_e;
endpackage

// File: rtl/ethtx_bufmem.sv
module ethtx_bufmem #(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [31:0]   rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [31:0]   rdata_b
);
  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/ethtx_regs.sv
module ethtx_regs
  import ethtx_pkg::*;
#(
  parameter int BUF_WORDS = 512,
  parameter int LEN_W     = 16,
  localparam int BUF_AW   = $clog2(BUF_WORDS),
  localparam int ADDR_W   = BUF_AW + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [31:0]           wdata,
  output logic [31:0]           rdata,
  output logic                  mem_we,
  input  logic [31:0]           mem_rdata,
  input  logic                  done,
  input  logic                  done_buf,
  output logic [1:0]            busy_s,
  output logic [1:0]            busy_p,
  output logic [1:0][LEN_W-1:0] len_o,
  output logic                  irq_o
);
  localparam logic [BUF_AW-1:0] LEN_IDX  = BUF_AW'(BUF_WORDS - 3);
  localparam logic [BUF_AW-1:0] GIE_IDX  = BUF_AW'(BUF_WORDS - 2);
  localparam logic [BUF_AW-1:0] CTRL_IDX = BUF_AW'(BUF_WORDS - 1);

  logic              sel_buf;
  logic [BUF_AW-1:0] widx;
  logic              hit_len, hit_ctrl, hit_gie;
  logic [1:0]        ien_all;

  assign sel_buf  = addr[ADDR_W-1];
  assign widx     = addr[BUF_AW-1:0];
  assign hit_len  = (widx == LEN_IDX);
  assign hit_ctrl = (widx == CTRL_IDX);
  assign hit_gie  = (widx == GIE_IDX) && !sel_buf;
  assign mem_we   = wr_en && !hit_len && !hit_ctrl && !hit_gie;

  for (genvar b = 0; b < 2; b++) begin : g_buf
    logic             bs_q, bs_d, bp_q, bp_d, ie_q, ie_d;
    logic [LEN_W-1:0] ln_q, ln_d;
    logic             wr_ctrl, accept, finish;

    assign wr_ctrl = wr_en && hit_ctrl && (sel_buf == 1'(b));
    assign accept  = wr_ctrl && !bs_q;
    assign finish  = done && (done_buf == 1'(b));

    always_comb begin
      ln_d = ln_q;
      bs_d = bs_q;
      bp_d = bp_q;
      ie_d = ie_q;
      if (wr_en && hit_len && (sel_buf == 1'(b))) begin
        ln_d = wdata[LEN_W-1:0];
      end
      if (finish) begin
        bs_d = 1'b0;
        bp_d = 1'b0;
      end
      if (accept) begin
        ie_d = wdata[CTL_I];
        if (wdata[CTL_S]) begin
          bs_d = 1'b1;
          bp_d = wdata[CTL_P];
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ln_q <= '0;
        bs_q <= 1'b0;
        bp_q <= 1'b0;
        ie_q <= 1'b0;
      end else begin
        ln_q <= ln_d;
        bs_q <= bs_d;
        bp_q <= bp_d;
        ie_q <= ie_d;
      end
    end

    assign busy_s[b]  = bs_q;
    assign busy_p[b]  = bp_q;
    assign ien_all[b] = ie_q;
    assign len_o[b]   = ln_q;

    AST_P_NEEDS_S: assert property (@(posedge clk) disable iff (!rst_n)
      bp_q |-> bs_q); // R6
    AST_DONE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      finish |-> bs_q); // R6
    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      finish |=> !bs_q); // R6
    AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && bs_q && !finish) |=> (bs_q && $stable(bp_q) && $stable(ie_q))); // R9
  end

  logic        gie_q, gie_d;
  logic        irq_q, irq_d;
  logic [31:0] rdata_q, rdata_d;

  always_comb begin
    gie_d = gie_q;
    if (wr_en && hit_gie) begin
      gie_d = wdata[GIE_BIT];
    end
    irq_d = done && ien_all[done_buf] && gie_q;
    rdata_d = rdata_q;
    if (rd_en) begin
      if (hit_len) begin
        rdata_d = 32'(len_o[sel_buf]);
      end else if (hit_ctrl) begin
        rdata_d = {28'd0, ien_all[sel_buf], 1'b0, busy_p[sel_buf], busy_s[sel_buf]};
      end else if (hit_gie) begin
        rdata_d = {gie_q, 31'd0};
      end else begin
        rdata_d = mem_rdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q   <= 1'b0;
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      gie_q   <= gie_d;
      irq_q   <= irq_d;
      rdata_q <= rdata_d;
    end
  end

  assign rdata = rdata_q;
  assign irq_o = irq_q;

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q); // R7
  AST_IRQ_FOLLOWS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(done)); // R7
endmodule

// File: rtl/ethtx_engine.sv
module ethtx_engine
  import ethtx_pkg::*;
#(
  parameter int BUF_WORDS = 512,
  parameter int LEN_W     = 16,
  localparam int BUF_AW    = $clog2(BUF_WORDS),
  localparam int ADDR_W    = BUF_AW + 1,
  localparam int IDX_W     = BUF_AW + 2,
  localparam int MAX_BYTES = (BUF_WORDS - 3) * 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            busy_s,
  input  logic [1:0]            busy_p,
  input  logic [1:0][LEN_W-1:0] len_i,
  output logic [ADDR_W-1:0]     rd_addr,
  input  logic [31:0]           rd_data,
  output logic                  tvalid,
  input  logic                  tready,
  output logic [7:0]            tdata,
  output logic                  tlast,
  output logic                  done,
  output logic                  done_buf,
  output logic [47:0]           mac_addr
);
  eng_state_e       state_q, state_d;
  logic             cur_q, cur_d;
  logic [IDX_W-1:0] idx_q, idx_d, cnt_q, cnt_d;
  logic [47:0]      mac_q, mac_d;
  logic             pick, sel;
  logic [LEN_W-1:0] len_sel;
  logic [IDX_W-1:0] len_eff;

  assign pick    = |busy_s;
  assign sel     = !busy_s[0];
  assign len_sel = len_i[sel];
  assign len_eff = (len_sel > LEN_W'(MAX_BYTES)) ? IDX_W'(MAX_BYTES) : len_sel[IDX_W-1:0];

  assign tvalid = (state_q == ENG_SEND);
  assign tlast  = tvalid && (idx_q == (cnt_q - IDX_W'(1)));

  always_comb begin
    case (idx_q[1:0])
      2'd0:    tdata = rd_data[7:0];
      2'd1:    tdata = rd_data[15:8];
      2'd2:    tdata = rd_data[23:16];
      default: tdata = rd_data[31:24];
    endcase
  end

  always_comb begin
    case (state_q)
      ENG_MAC_HI: rd_addr = {cur_q, BUF_AW'(0)};
      ENG_MAC_LO: rd_addr = {cur_q, BUF_AW'(1)};
      default:    rd_addr = {cur_q, idx_q[IDX_W-1:2]};
    endcase
  end

  assign done     = (state_q == ENG_FIN) || (state_q == ENG_MAC_LO) || (tvalid && tready && tlast);
  assign done_buf = cur_q;

  always_comb begin
    state_d = state_q;
    cur_d   = cur_q;
    idx_d   = idx_q;
    cnt_d   = cnt_q;
    mac_d   = mac_q;
    case (state_q)
      ENG_IDLE: begin
        if (pick) begin
          cur_d = sel;
          if (busy_p[sel]) begin
            state_d = ENG_MAC_HI;
          end else if (len_eff == '0) begin
            state_d = ENG_FIN;
          end else begin
            state_d = ENG_SEND;
            cnt_d   = len_eff;
            idx_d   = '0;
          end
        end
      end
      ENG_SEND: begin
        if (tready) begin
          idx_d = idx_q + IDX_W'(1);
          if (tlast) begin
            state_d = ENG_IDLE;
          end
        end
      end
      ENG_MAC_HI: begin
        mac_d[47:16] = {rd_data[7:0], rd_data[15:8], rd_data[23:16], rd_data[31:24]};
        state_d      = ENG_MAC_LO;
      end
      ENG_MAC_LO: begin
        mac_d[15:0] = {rd_data[7:0], rd_data[15:8]};
        state_d     = ENG_IDLE;
      end
      default: state_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      cur_q   <= 1'b0;
      idx_q   <= '0;
      cnt_q   <= '0;
      mac_q   <= '0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      idx_q   <= idx_d;
      cnt_q   <= cnt_d;
      mac_q   <= mac_d;
    end
  end

  assign mac_addr = mac_q;

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (tvalid && !tready) |=> (tvalid && $stable(tdata) && $stable(tlast))); // R4
  AST_SEND_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    tvalid |-> (busy_s[cur_q] && !busy_p[cur_q])); // R2
  AST_DONE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_MAC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    busy_p[cur_q] |-> !tvalid); // R5
endmodule

// File: rtl/eth_tx_frontend.sv
module eth_tx_frontend #(
  parameter int BUF_WORDS = 512,
  parameter int LEN_W     = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_wr,
  input  logic                      reg_rd,
  input  logic [$clog2(BUF_WORDS):0] reg_addr,
  input  logic [31:0]               reg_wdata,
  output logic [31:0]               reg_rdata,
  output logic                      tx_tvalid,
  input  logic                      tx_tready,
  output logic [7:0]                tx_tdata,
  output logic                      tx_tlast,
  output logic [47:0]               mac_addr,
  output logic                      irq
);
  localparam int ADDR_W = $clog2(BUF_WORDS) + 1;

  logic                  rst_meta, rst_sync_n;
  logic                  mem_we;
  logic [31:0]           mem_bus_rdata, mem_eng_rdata;
  logic [ADDR_W-1:0]     eng_rd_addr;
  logic                  eng_done, eng_done_buf;
  logic [1:0]            busy_s, busy_p;
  logic [1:0][LEN_W-1:0] len_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  ethtx_bufmem #(.DEPTH(2 * BUF_WORDS)) u_mem (
    .clk     (clk),
    .we      (mem_we),
    .waddr   (reg_addr),
    .wdata   (reg_wdata),
    .raddr_a (reg_addr),
    .rdata_a (mem_bus_rdata),
    .raddr_b (eng_rd_addr),
    .rdata_b (mem_eng_rdata)
  );

  ethtx_regs #(.BUF_WORDS(BUF_WORDS), .LEN_W(LEN_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (reg_wr),
    .rd_en     (reg_rd),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .rdata     (reg_rdata),
    .mem_we    (mem_we),
    .mem_rdata (mem_bus_rdata),
    .done      (eng_done),
    .done_buf  (eng_done_buf),
    .busy_s    (busy_s),
    .busy_p    (busy_p),
    .len_o     (len_w),
    .irq_o     (irq)
  );

  ethtx_engine #(.BUF_WORDS(BUF_WORDS), .LEN_W(LEN_W)) u_eng (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .busy_s   (busy_s),
    .busy_p   (busy_p),
    .len_i    (len_w),
    .rd_addr  (eng_rd_addr),
    .rd_data  (mem_eng_rdata),
    .tvalid   (tx_tvalid),
    .tready   (tx_tready),
    .tdata    (tx_tdata),
    .tlast    (tx_tlast),
    .done     (eng_done),
    .done_buf (eng_done_buf),
    .mac_addr (mac_addr)
  );

  AST_NO_STREAM_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy_s == 2'b00) |-> !tx_tvalid); // R2
endmodule

// File: tb/tb_eth_tx_frontend.sv
module tb_eth_tx_frontend;
  localparam int B1 = 512;
  localparam int LENK = 509;
  localparam int GIEK = 510;
  localparam int CTLK = 511;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [9:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tx_tvalid, tx_tready, tx_tlast, irq;
  logic [7:0]  tx_tdata;
  logic [47:0] mac_addr;

  int total = 0, bad = 0;
  int rdy_mode = 0, ph = 0;
  logic [7:0] cap [0:4095];
  int cap_n = 0, last_n = 0, last_pos = -1, irq_n = 0;

  always #10 clk = ~clk;

  eth_tx_frontend dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_tvalid(tx_tvalid), .tx_tready(tx_tready), .tx_tdata(tx_tdata),
    .tx_tlast(tx_tlast), .mac_addr(mac_addr), .irq(irq)
  );

  initial tx_tready = 1'b0;
  always @(negedge clk) begin
    case (rdy_mode)
      0: tx_tready <= 1'b0;
      1: tx_tready <= 1'b1;
      default: tx_tready <= (ph % 3) != 0;
    endcase
    ph++;
  end

  always @(posedge clk) begin
    if (tx_tvalid && tx_tready) begin
      cap[cap_n] = tx_tdata;
      if (tx_tlast) begin
        last_n++;
        last_pos = cap_n;
      end
      cap_n++;
    end
    if (irq) irq_n++;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clr();
    cap_n = 0; last_n = 0; last_pos = -1; irq_n = 0;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = 10'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = 10'(a);
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  function automatic logic [7:0] pat(input int seed, input int k);
    return 8'(seed + k * 13 + (k >> 3));
  endfunction

  task automatic fill(input int b, input int nbytes, input int seed);
    for (int w = 0; w < (nbytes + 3) / 4; w++)
      wr(b * B1 + w, {pat(seed, 4*w+3), pat(seed, 4*w+2), pat(seed, 4*w+1), pat(seed, 4*w)});
  endtask

  task automatic wait_idle(input int b);
    logic [31:0] d;
    for (int i = 0; i < 6000; i++) begin
      rd(b * B1 + CTLK, d);
      if (d[0] == 1'b0) break;
    end
    repeat (2) @(negedge clk);
  endtask

  // Send one frame and check bytes, tlast placement and interrupt count.
  task automatic t_send(input int b, input logic [31:0] len_wr, input int exp_len,
                        input bit ien, input int exp_irq, input int seed, input int mode,
                        input string tag);
    int errs = 0;
    fill(b, exp_len, seed);
    clr();
    rdy_mode = mode;
    wr(b * B1 + LENK, len_wr);
    wr(b * B1 + CTLK, ien ? 32'h9 : 32'h1);
    wait_idle(b);
    rdy_mode = 0;
    chk(cap_n == exp_len, {tag, " R2 byte count"}, cap_n, exp_len);
    for (int k = 0; k < exp_len && k < cap_n; k++)
      if (cap[k] !== pat(seed, k)) errs++;
    chk(errs == 0, {tag, " R3 byte order"}, errs, 0);
    chk(last_n == (exp_len > 0 ? 1 : 0) && last_pos == exp_len - 1,
        {tag, " R3 tlast position"}, last_pos, exp_len - 1);
    chk(irq_n == exp_irq, {tag, " R7 irq count"}, irq_n, exp_irq);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk(irq == 1'b0 && tx_tvalid == 1'b0, "R12 outputs idle", {irq, tx_tvalid}, 0);
    chk(mac_addr == 48'h0, "R12 mac zero", mac_addr, 0);
    rd(CTLK, d);      chk(d == 32'h0, "R12 ctrl0 zero", d, 0);
    rd(B1 + CTLK, d); chk(d == 32'h0, "R12 ctrl1 zero", d, 0);
  endtask

  task automatic t_map();
    logic [31:0] d;
    wr(B1 + 3, 32'hDEAD_BEEF);
    rd(B1 + 3, d);      chk(d == 32'hDEAD_BEEF, "R1 data word readback", d, 32'hDEAD_BEEF);
    wr(B1 + LENK, 32'hABCD_1234);
    rd(B1 + LENK, d);   chk(d == 32'h0000_1234, "R1 length 16-bit", d, 32'h1234);
    wr(GIEK, 32'h8000_5A5A);
    rd(GIEK, d);        chk(d == 32'h8000_0000, "R8 gie bit31 only", d, 32'h8000_0000);
  endtask

  task automatic t_mac(input int b, input int seed);
    logic [47:0] exp;
    logic [31:0] d;
    fill(b, 8, seed);
    exp = {pat(seed,0), pat(seed,1), pat(seed,2), pat(seed,3), pat(seed,4), pat(seed,5)};
    clr();
    rdy_mode = 1;
    wr(b * B1 + CTLK, 32'hB);
    rd(b * B1 + CTLK, d);
    chk(d == 32'hB, "R6 busy readback S and P", d, 32'hB);
    wait_idle(b);
    rdy_mode = 0;
    chk(mac_addr == exp, "R5 mac assembled", mac_addr, exp);
    chk(cap_n == 0, "R5 no bytes streamed", cap_n, 0);
    chk(irq_n == 1, "R7 irq after mac load", irq_n, 1);
    rd(b * B1 + CTLK, d);
    chk(d == 32'h8, "R6 S and P clear", d, 32'h8);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] d;
    logic [47:0] mac_before;
    mac_before = mac_addr;
    fill(1, 4, 77);
    clr();
    rdy_mode = 0;
    wr(B1 + LENK, 32'd4);
    wr(B1 + CTLK, 32'h9);
    rd(B1 + CTLK, d);
    chk(d == 32'h9, "R6 S reads 1 while sending", d, 32'h9);
    wr(B1 + CTLK, 32'h3);
    rd(B1 + CTLK, d);
    chk(d == 32'h9, "R9 busy write ignored", d, 32'h9);
    rdy_mode = 1;
    wait_idle(1);
    rdy_mode = 0;
    chk(cap_n == 4 && last_n == 1, "R9 single frame sent", cap_n, 4);
    chk(mac_addr == mac_before, "R9 mac untouched", mac_addr, mac_before);
    chk(irq_n == 1, "R9 irq once", irq_n, 1);
  endtask

  task automatic t_nop();
    logic [31:0] d;
    clr();
    rdy_mode = 1;
    wr(CTLK, 32'h2);
    rd(CTLK, d);
    chk(d == 32'h0, "R11 S=0 starts nothing, I cleared", d, 0);
    wr(CTLK, 32'hA);
    rd(CTLK, d);
    repeat (4) @(negedge clk);
    rdy_mode = 0;
    chk(d == 32'h8, "R11 I updated only", d, 32'h8);
    chk(cap_n == 0 && irq_n == 0, "R11 no activity", cap_n, 0);
  endtask

  task automatic t_gating();
    wr(GIEK, 32'h0);
    t_send(0, 32'd3, 3, 1'b1, 0, 9, 1, "gie off");
    wr(B1 + GIEK, 32'h8000_0000);
    t_send(1, 32'd2, 2, 1'b1, 0, 11, 1, "R8 word1022 no gie");
    wr(GIEK, 32'h8000_0000);
    t_send(0, 32'd5, 5, 1'b0, 0, 13, 1, "R7 I off");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_map();
    t_send(0, 32'd6, 6, 1'b1, 1, 21, 1, "R2 buf0");
    t_send(1, 32'd11, 11, 1'b1, 1, 40, 2, "R4 buf1 backpressure");
    t_mac(1, 90);
    t_mac(0, 5);
    t_busy_ignore();
    t_nop();
    t_gating();
    t_send(0, 32'd0, 0, 1'b1, 1, 3, 1, "R10 zero length");
    t_send(1, 32'h0000_FFFF, 2036, 1'b1, 1, 55, 1, "R10 clamp");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R2 actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule